// File: doc/BRIEF.md
# Ethernet Transmit Status Register

This block is the status-and-control core that records the outcome of each frame a MAC transmits. The transmit and receive engines feed it event strobes: underrun, collisions, deferral, carrier checks, frame class, completion and receive FIFO overrun. It also takes a raw active-low link pin and byte-time and inter-frame-gap timing indications. It keeps a live 16-bit status word and owns the transmit-enable bit, which fatal transmit errors force low.

The status bits do not all last the same length of time. Fatal transmit errors (underrun, lost carrier, late collision) stay set until software writes transmit enable high again. The deferral flags clear at the end of every packet. The outcome bits are reloaded at each completion and hold until the next one. The receive overrun bit clears on the next valid preamble, and link status is live. At each packet completion the block presents a snapshot word that can be stored as the first word of that packet's buffer. It also keeps four saturating 4-bit event counters and a shared rollover flag, and raises interrupt requests for link changes and receive overrun.

Top module: `eth_txstat_core`

## Requirements
- R1: After reset, with the link pin high, `status` reads 0, `txena` is low, `ctr_word` is 0 and no interrupt is raised. Bit map of `status`: 15 underrun, 14 link OK, 13 receive overrun, 12 counter rollover, 11 excessive deferral, 10 lost carrier, 9 late collision, 8 always 0, 7 deferred, 6 broadcast, 5 SQE test error, 4 sixteen collisions, 3 multicast, 2 multiple collisions, 1 single collision, 0 success.
- R2: A `tx_underrun` strobe sets bit 15 and drives `txena` low on the next cycle. Writing transmit enable as 0 leaves bit 15 set.
- R3: A `col_det` strobe that arrives when more than `LATE_COL_BYTES` byte ticks have passed since `frame_start` sets bit 9, pulses `jam_req` for one cycle and drives `txena` low. At exactly `LATE_COL_BYTES` ticks it has no effect on bit 9, `jam_req` or `txena`.
- R4: `preamble_end` with `carrier` low sets bit 10 and drives `txena` low, but only while `carrier_mon_en` is high. With monitoring off, the same stimulus has no effect.
- R5: When a fatal event and a write of transmit enable as 1 arrive in the same cycle, the fatal event wins: the bit sets and `txena` goes low.
- R6: Bit 14 is the inverse of `link_n_pin` after a two-flop synchroniser, so it follows a pin change two clocks later. `irq_link` is high for exactly the one cycle in which bit 14 takes a new value.
- R7: An `rx_overrun` strobe sets bit 13, pulses `rx_flush` for one cycle and sets `irq_rx_ovr`. `rx_preamble_ok` clears bit 13 but not `irq_rx_ovr`, which clears only on `rx_irq_clr`.
- R8: While `defer_active` is high, byte ticks are counted. The tick that takes the count past `EXC_DEFER_BYTES` sets bit 11. A count of exactly `EXC_DEFER_BYTES` does not set it. Bit 11 clears on `tx_done`.
- R9: `carrier` high while `ifg_early` is high sets bit 7. Bit 7 clears on `tx_done`.
- R10: On `tx_done`, bits 0, 6, 3 and 5 load from `done_ok`, `done_bcast`, `done_mcast` and `done_sqe`. A `done_col_cnt` of 1 sets bit 1, 2 to 15 sets bit 2, and 16 or more sets bit 4. These bits hold until the next `tx_done`.
- R11: `snap_valid` is high for the one cycle after `tx_done`. During that cycle `snap_word` equals `status`, except that bits 7 and 11 carry the values they had just before the completion cleared them.
- R12: `ctr_word` holds four 4-bit counters: [3:0] single-collision frames, [7:4] multiple-collision frames, [11:8] deferred frames and [15:12] excessive-deferral frames. Each counts at `tx_done` and saturates at 15.
- R13: Bit 12 sets when any counter reaches 15. A `ctr_rd` strobe clears all counters and bit 12 on the next cycle.
- R14: A transmit-enable write (`txena_wr`) loads `txena` from `txena_wdata`. A write of 1 also clears bits 15, 10 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_n_pin | input | 1 | Raw active-low link pin |
| byte_tick | input | 1 | One byte time has elapsed |
| frame_start | input | 1 | Transmit frame begins, restarts byte count |
| defer_active | input | 1 | Transmitter is deferring |
| col_det | input | 1 | Collision seen during transmit |
| ifg_early | input | 1 | Within first part of inter-frame gap |
| carrier | input | 1 | Carrier sense |
| preamble_end | input | 1 | End of transmitted preamble |
| carrier_mon_en | input | 1 | Carrier monitoring enable |
| tx_underrun | input | 1 | Transmit underrun strobe |
| tx_done | input | 1 | Packet completion strobe |
| done_ok | input | 1 | Completed frame succeeded |
| done_bcast | input | 1 | Completed frame was broadcast |
| done_mcast | input | 1 | Completed frame was multicast |
| done_sqe | input | 1 | SQE test error on completed frame |
| done_col_cnt | input | 5 | Collisions suffered by completed frame |
| rx_overrun | input | 1 | Receive FIFO overrun strobe |
| rx_preamble_ok | input | 1 | Valid receive preamble detected |
| rx_irq_clr | input | 1 | CPU clears overrun interrupt |
| txena_wr | input | 1 | Software write of transmit enable |
| txena_wdata | input | 1 | Value written to transmit enable |
| ctr_rd | input | 1 | Counter register read strobe |
| status | output | 16 | Live status word |
| txena | output | 1 | Transmit enable |
| jam_req | output | 1 | Request to send jam after late collision |
| snap_valid | output | 1 | Snapshot word valid |
| snap_word | output | 16 | Per-packet completion snapshot |
| ctr_word | output | 16 | Four packed event counters |
| rx_flush | output | 1 | Flush receive FIFO |
| irq_rx_ovr | output | 1 | Sticky receive overrun interrupt |
| irq_link | output | 1 | Link change interrupt pulse |

## Verification
The assertions assume that every event input is a single-cycle strobe, that `done_col_cnt` and the frame-class qualifiers are valid only alongside `tx_done`, and that `link_n_pin` stays steady for at least three clocks between changes, so that every link change produces its own interrupt pulse. The stimulus drives each strobe high for one clock at the falling edge. It holds the link pin for many cycles after each change. It never combines a completion with a counter read or a link edge, except in the one deliberate case where a fatal event meets an enable write.

// File: rtl/eth_txstat_pkg.sv
package eth_txstat_pkg;

  localparam int ST_W   = 16;
  localparam int CNT_W  = 4;
  localparam int NUM_CNT = 4;
  localparam int COLCNT_W = 5;

  // counter slots in ctr_word
  localparam int SLOT_SNGL = 0;
  localparam int SLOT_MULT = 1;
  localparam int SLOT_DEFR = 2;
  localparam int SLOT_EXCD = 3;

  // field order is MSB first, so the struct packs straight onto the bit map
  typedef struct packed {
    logic unrn;
    logic link;
    logic rxovr;
    logic roll;
    logic excdef;
    logic lostcs;
    logic latecol;
    logic rsvd;
    logic defr;
    logic bcast;
    logic sqe;
    logic col16;
    logic mcast;
    logic multcol;
    logic snglcol;
    logic ok;
  } txstat_word_t;

  typedef struct packed {
    logic col16;
    logic multi;
    logic single;
  } col_class_t;

  function automatic col_class_t classify_cols(input logic [COLCNT_W-1:0] n);
    col_class_t c;
    c.single = (n == COLCNT_W'(1));
    c.multi  = (n >= COLCNT_W'(2)) && (n <= COLCNT_W'(15));
    c.col16  = (n >= COLCNT_W'(16));
    return c;
  endfunction

endpackage

// File: rtl/txstat_link_sync.sv
module txstat_link_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic link_n_pin,
  output logic link_ok,
  output logic link_irq
);

  logic s1_q, s2_q, s3_q;
  logic s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = link_n_pin;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign link_ok  = ~s2_q;
  assign link_irq = s2_q ^ s3_q;

  // R6
  link_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_irq |-> (link_ok != $past(link_ok)));

endmodule

// File: rtl/txstat_timers.sv
module txstat_timers #(
  parameter int EXC_DEFER_BYTES = 3036,
  parameter int LATE_COL_BYTES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_tick,
  input  logic frame_start,
  input  logic defer_active,
  input  logic pkt_done,
  input  logic col_det,
  output logic late_col_ev,
  output logic exc_defer_ev
);

  localparam int DEF_W = $clog2(EXC_DEFER_BYTES + 2);
  localparam int FRM_W = $clog2(LATE_COL_BYTES + 2);
  localparam logic [DEF_W-1:0] DEF_LIM = DEF_W'(EXC_DEFER_BYTES);
  localparam logic [FRM_W-1:0] FRM_LIM = FRM_W'(LATE_COL_BYTES);

  logic [DEF_W-1:0] def_cnt_q, def_cnt_d;
  logic [FRM_W-1:0] frm_cnt_q, frm_cnt_d;
  logic             def_tick;

  assign def_tick = byte_tick && defer_active;

  always_comb begin
    def_cnt_d = def_cnt_q;
    if (pkt_done)
      def_cnt_d = '0;
    else if (def_tick && (def_cnt_q <= DEF_LIM))
      def_cnt_d = def_cnt_q + 1'b1;
  end

  always_comb begin
    frm_cnt_d = frm_cnt_q;
    if (frame_start)
      frm_cnt_d = '0;
    else if (byte_tick && (frm_cnt_q <= FRM_LIM))
      frm_cnt_d = frm_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_cnt_q <= '0;
      frm_cnt_q <= '0;
    end else begin
      def_cnt_q <= def_cnt_d;
      frm_cnt_q <= frm_cnt_d;
    end
  end

  assign exc_defer_ev = def_tick && !pkt_done && (def_cnt_q == DEF_LIM);
  assign late_col_ev  = col_det && !frame_start && (frm_cnt_q > FRM_LIM);

  // R8
  exc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_defer_ev |=> !exc_defer_ev);

endmodule

// File: rtl/txstat_evcnt.sv
module txstat_evcnt #(
  parameter int NUM = 4,
  parameter int W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM-1:0]   inc,
  input  logic             clr,
  output logic [NUM*W-1:0] cnt_word,
  output logic             roll
);

  localparam logic [W-1:0] CMAX = '1;

  logic [NUM-1:0] at_max_d;
  logic [NUM-1:0] at_max_q;
  logic           roll_q, roll_d;

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [W-1:0] c_q, c_d;

    always_comb begin
      if (clr)
        c_d = inc[g] ? W'(1) : '0;
      else if (inc[g] && (c_q != CMAX))
        c_d = c_q + 1'b1;
      else
        c_d = c_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_d;
    end

    assign cnt_word[g*W +: W] = c_q;
    assign at_max_d[g] = (c_d == CMAX);
    assign at_max_q[g] = (c_q == CMAX);

    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max_q[g] && !clr) |=> at_max_q[g]);
  end

  always_comb roll_d = (roll_q && !clr) || (|at_max_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) roll_q <= 1'b0;
    else        roll_q <= roll_d;
  end

  assign roll = roll_q;

  // R13
  roll_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_q |-> (|at_max_q));

endmodule

// File: rtl/eth_txstat_core.sv
module eth_txstat_core
  import eth_txstat_pkg::*;
#(
  parameter int EXC_DEFER_BYTES = 3036,
  parameter int LATE_COL_BYTES  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_n_pin,
  input  logic                byte_tick,
  input  logic                frame_start,
  input  logic                defer_active,
  input  logic                col_det,
  input  logic                ifg_early,
  input  logic                carrier,
  input  logic                preamble_end,
  input  logic                carrier_mon_en,
  input  logic                tx_underrun,
  input  logic                tx_done,
  input  logic                done_ok,
  input  logic                done_bcast,
  input  logic                done_mcast,
  input  logic                done_sqe,
  input  logic [COLCNT_W-1:0] done_col_cnt,
  input  logic                rx_overrun,
  input  logic                rx_preamble_ok,
  input  logic                rx_irq_clr,
  input  logic                txena_wr,
  input  logic                txena_wdata,
  input  logic                ctr_rd,
  output logic [ST_W-1:0]     status,
  output logic                txena,
  output logic                jam_req,
  output logic                snap_valid,
  output logic [ST_W-1:0]     snap_word,
  output logic [ST_W-1:0]     ctr_word,
  output logic                rx_flush,
  output logic                irq_rx_ovr,
  output logic                irq_link
);

  // reset: asserted asynchronously, released on the clock
  logic rsync1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rsync1_q   <= 1'b1;
      rst_sync_n <= rsync1_q;
    end
  end

  logic link_ok, late_ev, exc_ev, roll;

  txstat_link_sync u_link (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .link_n_pin (link_n_pin),
    .link_ok    (link_ok),
    .link_irq   (irq_link)
  );

  txstat_timers #(
    .EXC_DEFER_BYTES (EXC_DEFER_BYTES),
    .LATE_COL_BYTES  (LATE_COL_BYTES)
  ) u_timers (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .byte_tick    (byte_tick),
    .frame_start  (frame_start),
    .defer_active (defer_active),
    .pkt_done     (tx_done),
    .col_det      (col_det),
    .late_col_ev  (late_ev),
    .exc_defer_ev (exc_ev)
  );

  // fatal-error and enable state
  logic unrn_q, unrn_d, lost_q, lost_d, late_q, late_d;
  logic txena_q, txena_d, jam_q, jam_d;
  logic lost_ev, fatal_ev, reenable;

  // per-packet deferral state and its pre-clear copy for the snapshot
  logic defr_q, defr_d, excdef_q, excdef_d;
  logic defr_now, exc_now;
  logic defr_hold_q, exc_hold_q, snapv_q;

  // completion outcome bits
  logic ok_q, bc_q, mc_q, sqe_q, c16_q, mul_q, sgl_q;
  logic ok_d, bc_d, mc_d, sqe_d, c16_d, mul_d, sgl_d;
  col_class_t cc;

  // receive overrun
  logic ovr_q, ovr_d, irqovr_q, irqovr_d, flush_q;

  logic [NUM_CNT-1:0] cnt_inc;

  always_comb begin
    lost_ev  = preamble_end && carrier_mon_en && !carrier;
    fatal_ev = tx_underrun || late_ev || lost_ev;
    reenable = txena_wr && txena_wdata;

    unrn_d = tx_underrun ? 1'b1 : (reenable ? 1'b0 : unrn_q);
    late_d = late_ev     ? 1'b1 : (reenable ? 1'b0 : late_q);
    lost_d = lost_ev     ? 1'b1 : (reenable ? 1'b0 : lost_q);

    if (fatal_ev)      txena_d = 1'b0;
    else if (txena_wr) txena_d = txena_wdata;
    else               txena_d = txena_q;

    jam_d = late_ev;
  end

  always_comb begin
    defr_now = defr_q   || (ifg_early && carrier);
    exc_now  = excdef_q || exc_ev;
    defr_d   = tx_done ? 1'b0 : defr_now;
    excdef_d = tx_done ? 1'b0 : exc_now;
  end

  always_comb begin
    cc = classify_cols(done_col_cnt);
    {ok_d, bc_d, mc_d, sqe_d, c16_d, mul_d, sgl_d} =
      {ok_q, bc_q, mc_q, sqe_q, c16_q, mul_q, sgl_q};
    if (tx_done)
      {ok_d, bc_d, mc_d, sqe_d, c16_d, mul_d, sgl_d} =
        {done_ok, done_bcast, done_mcast, done_sqe, cc.col16, cc.multi, cc.single};
  end

  always_comb begin
    ovr_d    = rx_overrun ? 1'b1 : (rx_preamble_ok ? 1'b0 : ovr_q);
    irqovr_d = rx_overrun ? 1'b1 : (rx_irq_clr     ? 1'b0 : irqovr_q);
  end

  always_comb begin
    cnt_inc            = '0;
    cnt_inc[SLOT_SNGL] = tx_done && cc.single;
    cnt_inc[SLOT_MULT] = tx_done && cc.multi;
    cnt_inc[SLOT_DEFR] = tx_done && defr_now;
    cnt_inc[SLOT_EXCD] = tx_done && exc_now;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      unrn_q <= 1'b0; late_q <= 1'b0; lost_q <= 1'b0;
      txena_q <= 1'b0; jam_q <= 1'b0;
      defr_q <= 1'b0; excdef_q <= 1'b0;
      defr_hold_q <= 1'b0; exc_hold_q <= 1'b0; snapv_q <= 1'b0;
      {ok_q, bc_q, mc_q, sqe_q, c16_q, mul_q, sgl_q} <= '0;
      ovr_q <= 1'b0; irqovr_q <= 1'b0; flush_q <= 1'b0;
    end else begin
      unrn_q <= unrn_d; late_q <= late_d; lost_q <= lost_d;
      txena_q <= txena_d; jam_q <= jam_d;
      defr_q <= defr_d; excdef_q <= excdef_d;
      snapv_q <= tx_done;
      if (tx_done) begin
        defr_hold_q <= defr_now;
        exc_hold_q  <= exc_now;
      end
      {ok_q, bc_q, mc_q, sqe_q, c16_q, mul_q, sgl_q} <=
        {ok_d, bc_d, mc_d, sqe_d, c16_d, mul_d, sgl_d};
      ovr_q <= ovr_d; irqovr_q <= irqovr_d; flush_q <= rx_overrun;
    end
  end

  txstat_evcnt #(.NUM(NUM_CNT), .W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .inc      (cnt_inc),
    .clr      (ctr_rd),
    .cnt_word (ctr_word),
    .roll     (roll)
  );

  txstat_word_t st, snap;
  always_comb begin
    st.unrn    = unrn_q;
    st.link    = link_ok;
    st.rxovr   = ovr_q;
    st.roll    = roll;
    st.excdef  = excdef_q;
    st.lostcs  = lost_q;
    st.latecol = late_q;
    st.rsvd    = 1'b0;
    st.defr    = defr_q;
    st.bcast   = bc_q;
    st.sqe     = sqe_q;
    st.col16   = c16_q;
    st.mcast   = mc_q;
    st.multcol = mul_q;
    st.snglcol = sgl_q;
    st.ok      = ok_q;
    snap        = st;
    snap.defr   = defr_hold_q;
    snap.excdef = exc_hold_q;
  end

  assign status     = st;
  assign snap_word  = snap;
  assign snap_valid = snapv_q;
  assign txena      = txena_q;
  assign jam_req    = jam_q;
  assign rx_flush   = flush_q;
  assign irq_rx_ovr = irqovr_q;

  // R2
  underrun_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_underrun |=> (!txena && status[15]));

  // R3
  late_jam_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    jam_req |-> (status[9] && !txena));

  // R7
  ovr_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_overrun |=> (irq_rx_ovr && rx_flush && status[13]));

  // R8
  exc_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exc_ev && !tx_done) |=> status[11]);

  // R11
  snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snap_valid |-> $past(tx_done));

  // R14
  reenable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (txena_wr && txena_wdata && !tx_underrun && !col_det && !preamble_end)
      |=> (txena && !status[15]));

endmodule

// File: tb/test_eth_txstat_core.sv
module test_eth_txstat_core;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_n_pin = 1'b1;
  logic byte_tick = 0, frame_start = 0, defer_active = 0, col_det = 0;
  logic ifg_early = 0, carrier = 0, preamble_end = 0, carrier_mon_en = 0;
  logic tx_underrun = 0, tx_done = 0, done_ok = 0, done_bcast = 0;
  logic done_mcast = 0, done_sqe = 0;
  logic [4:0] done_col_cnt = '0;
  logic rx_overrun = 0, rx_preamble_ok = 0, rx_irq_clr = 0;
  logic txena_wr = 0, txena_wdata = 0, ctr_rd = 0;
  logic [15:0] status, snap_word, ctr_word;
  logic txena, jam_req, snap_valid, rx_flush, irq_rx_ovr, irq_link;

  always #4 clk = ~clk;

  eth_txstat_core i_eth_txstat_core (
    .clk(clk), .rst_n(rst_n), .link_n_pin(link_n_pin),
    .byte_tick(byte_tick), .frame_start(frame_start), .defer_active(defer_active),
    .col_det(col_det), .ifg_early(ifg_early), .carrier(carrier),
    .preamble_end(preamble_end), .carrier_mon_en(carrier_mon_en),
    .tx_underrun(tx_underrun), .tx_done(tx_done), .done_ok(done_ok),
    .done_bcast(done_bcast), .done_mcast(done_mcast), .done_sqe(done_sqe),
    .done_col_cnt(done_col_cnt), .rx_overrun(rx_overrun),
    .rx_preamble_ok(rx_preamble_ok), .rx_irq_clr(rx_irq_clr),
    .txena_wr(txena_wr), .txena_wdata(txena_wdata), .ctr_rd(ctr_rd),
    .status(status), .txena(txena), .jam_req(jam_req), .snap_valid(snap_valid),
    .snap_word(snap_word), .ctr_word(ctr_word), .rx_flush(rx_flush),
    .irq_rx_ovr(irq_rx_ovr), .irq_link(irq_link)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [15:0] snap_exp_q[$];

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // scoreboard monitor: R11 snapshot words
  always @(negedge clk) begin
    if (rst_n && snap_valid) begin
      if (snap_exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R11 unexpected snapshot: got %h expected none", snap_word);
      end else begin
        chk("R11", "snapshot", snap_word, snap_exp_q.pop_front());
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_txena(input logic v);
    txena_wr = 1; txena_wdata = v; cyc(); txena_wr = 0; txena_wdata = 0;
  endtask

  task automatic do_done(input logic ok, input logic bc, input logic mc,
                         input logic sqe, input logic [4:0] ncol,
                         input logic [15:0] exp_snap);
    snap_exp_q.push_back(exp_snap);
    tx_done = 1; done_ok = ok; done_bcast = bc; done_mcast = mc;
    done_sqe = sqe; done_col_cnt = ncol;
    cyc();
    tx_done = 0; done_ok = 0; done_bcast = 0; done_mcast = 0;
    done_sqe = 0; done_col_cnt = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();

    // R1 reset state
    chk("R1", "status", status, 16'h0000);
    chk("R1", "txena", {15'b0, txena}, 16'h0001 & 16'h0000);
    chk("R1", "ctr_word", ctr_word, 16'h0000);
    chk("R1", "irqs", {14'b0, irq_link, irq_rx_ovr}, 16'h0000);

    // R14 enable write
    wr_txena(1);
    chk("R14", "txena set", {15'b0, txena}, 16'h0001);

    // R2 underrun
    tx_underrun = 1; cyc(); tx_underrun = 0;
    chk("R2", "status", status, 16'h8000);
    chk("R2", "txena low", {15'b0, txena}, 16'h0000);
    wr_txena(0);
    chk("R2", "write 0 keeps bit15", status, 16'h8000);
    wr_txena(1);
    chk("R14", "reenable clears", status, 16'h0000);
    chk("R14", "txena back", {15'b0, txena}, 16'h0001);

    // R5 fatal beats simultaneous enable
    tx_underrun = 1; txena_wr = 1; txena_wdata = 1; cyc();
    tx_underrun = 0; txena_wr = 0; txena_wdata = 0;
    chk("R5", "status", status, 16'h8000);
    chk("R5", "txena", {15'b0, txena}, 16'h0000);
    wr_txena(1);

    // R3 late collision boundary
    frame_start = 1; cyc(); frame_start = 0;
    byte_tick = 1; repeat (64) cyc(); byte_tick = 0;
    col_det = 1; cyc(); col_det = 0;
    chk("R3", "at limit status", status, 16'h0000);
    chk("R3", "at limit txena/jam", {14'b0, txena, jam_req}, 16'h0002);
    byte_tick = 1; cyc(); byte_tick = 0;
    col_det = 1; cyc(); col_det = 0;
    chk("R3", "late status", status, 16'h0200);
    chk("R3", "late txena/jam", {14'b0, txena, jam_req}, 16'h0001);
    cyc();
    chk("R3", "jam one cycle", {15'b0, jam_req}, 16'h0000);
    wr_txena(1);
    chk("R14", "late cleared", status, 16'h0000);

    // R4 lost carrier
    preamble_end = 1; carrier = 0; carrier_mon_en = 0; cyc(); preamble_end = 0;
    chk("R4", "monitor off status", status, 16'h0000);
    chk("R4", "monitor off txena", {15'b0, txena}, 16'h0001);
    carrier_mon_en = 1;
    preamble_end = 1; cyc(); preamble_end = 0;
    chk("R4", "lost status", status, 16'h0400);
    chk("R4", "lost txena", {15'b0, txena}, 16'h0000);
    carrier_mon_en = 0;
    wr_txena(1);
    chk("R14", "lost cleared", status, 16'h0000);

    // R6 link
    link_n_pin = 0; cyc();
    chk("R6", "one edge", {14'b0, status[14], irq_link}, 16'h0000);
    cyc();
    chk("R6", "two edges", {14'b0, status[14], irq_link}, 16'h0003);
    cyc();
    chk("R6", "irq one cycle", {14'b0, status[14], irq_link}, 16'h0002);

    // R7 receive overrun
    rx_overrun = 1; cyc(); rx_overrun = 0;
    chk("R7", "set", {status[15:8], 5'b0, rx_flush, irq_rx_ovr, 1'b0}, 16'h6006);
    cyc();
    chk("R7", "flush pulse", {15'b0, rx_flush}, 16'h0000);
    rx_preamble_ok = 1; cyc(); rx_preamble_ok = 0;
    chk("R7", "preamble clears bit", status, 16'h4000);
    chk("R7", "irq sticky", {15'b0, irq_rx_ovr}, 16'h0001);
    rx_irq_clr = 1; cyc(); rx_irq_clr = 0;
    chk("R7", "irq cleared", {15'b0, irq_rx_ovr}, 16'h0000);

    // R9 deferred, R10 outcome, R11 snapshot, R12 counters
    ifg_early = 1; carrier = 1; cyc(); ifg_early = 0; carrier = 0;
    chk("R9", "deferred set", status, 16'h4080);
    do_done(1, 1, 0, 0, 5'd1, 16'h40C3);
    chk("R9", "deferred cleared at done", status, 16'h4043);
    chk("R12", "single+defer", ctr_word, 16'h0101);
    do_done(0, 0, 1, 1, 5'd16, 16'h4038);
    chk("R10", "16 collisions", status, 16'h4038);
    do_done(0, 0, 0, 0, 5'd5, 16'h4004);
    chk("R10", "multiple", status, 16'h4004);
    chk("R12", "multi counted", ctr_word, 16'h0111);

    // R8 excessive deferral boundary
    defer_active = 1; byte_tick = 1;
    repeat (3036) cyc();
    byte_tick = 0;
    chk("R8", "at limit", status, 16'h4004);
    byte_tick = 1; cyc(); byte_tick = 0; defer_active = 0;
    chk("R8", "past limit", status, 16'h4804);
    do_done(1, 0, 0, 0, 5'd0, 16'h4801);
    chk("R8", "cleared at done", status, 16'h4001);
    chk("R12", "exc counted", ctr_word, 16'h1111);
    cyc();
    chk("R10", "outcome held", status, 16'h4001);

    // R12 saturation and R13 rollover
    for (int k = 1; k <= 15; k++)
      do_done(1, 0, 0, 0, 5'd1, (k >= 14) ? 16'h5003 : 16'h4003);
    chk("R12", "saturated", ctr_word, 16'h111F);
    chk("R13", "rollover set", status, 16'h5003);
    ctr_rd = 1; cyc(); ctr_rd = 0;
    chk("R13", "read clears counters", ctr_word, 16'h0000);
    chk("R13", "read clears rollover", status, 16'h4003);

    repeat (2) cyc();
    chk("R11", "all snapshots seen", 16'(snap_exp_q.size()), 16'h0000);

    finished = 1;
    report();
  end

endmodule